// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two 8-bit buses, A and B, without inverting the data. Each direction has four controls of its own: a capture clock, a storage register, a source select and an output enable. A direction can pass live data from the opposite bus, or it can drive the contents of its own storage register. Both directions may drive at the same moment. With both selects high, the stored values cross over in opposite directions. With both selects low, the two buses form a loop that keeps whatever value they carried last.

Every bus pin appears as three signals: a separate input, an output and an output enable. This keeps the block free of tristate logic. A wrapper at the chip edge owns the real tristate buffers. Each register captures the observed value of its bus on every rising edge of its own clock, whatever the selects and enables are set to.

The observed value of a bus is defined as follows:
- When the block does not drive the bus, it is the external input.
- When the block drives the bus, it is the block's own output.

Inside the block, the live loop is broken by a level-sensitive keeper. Synthesis therefore sees no combinational cycle.

Top module: `dual_reg_xcvr`

## Requirements
- R1: The data path is 8 bits wide and non-inverting. A driven output bit always equals the source bit it was taken from.
- R2: On each rising edge of `clk_ab` with `rst` low, the A-side register captures the observed value of bus A. This happens for every setting of `sel_ab`, `sel_ba`, `oe_ab` and `oe_ba_n`.
- R3: On each rising edge of `clk_ba` with `rst` low, the B-side register captures the observed value of bus B. This happens for every setting of `sel_ab`, `sel_ba`, `oe_ab` and `oe_ba_n`.
- R4: Bus B is driven (`b_oe`=1) only when `oe_ab`=1, so that enable is active high. Bus A is driven (`a_oe`=1) only when `oe_ba_n`=0, so that enable is active low.
- R5: When a direction is enabled and its select is 1, it drives its stored register: `b_out` equals the A-side register, and `a_out` equals the B-side register.
- R6: When a direction is enabled and its select is 0, it drives the observed value of the opposite bus.
- R7: With both enables active and both selects at 1, stored A data drives bus B while stored B data drives bus A in the same cycle.
- R8: With both enables active and both selects at 0, both buses keep the values they had just before the loop formed, and they ignore changes on `a_in` and `b_in`.
- R9: One bus can be stored into both registers. When A drives B live and both clocks rise, both registers hold the A value (and likewise from B).
- R10: A rising edge of either clock while `rst` is 1 clears that register to 0. While `rst` is 1, both `a_oe` and `b_oe` are 0.
- R11: With `oe_ab`=0 and `oe_ba_n`=1 the block isolates the buses. `a_oe`=`b_oe`=0, and `a_out`, `b_out` follow `a_in`, `b_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Capture clock for the A-side register (feeds bus B) |
| clk_ba | input | 1 | Capture clock for the B-side register (feeds bus A) |
| rst | input | 1 | Active-high reset; synchronous to each capture clock |
| oe_ab | input | 1 | Enable for driving bus B, active high |
| oe_ba_n | input | 1 | Enable for driving bus A, active low |
| sel_ab | input | 1 | Bus B source: 0 live bus A, 1 stored A register |
| sel_ba | input | 1 | Bus A source: 0 live bus B, 1 stored B register |
| a_in | input | 8 | Value seen on bus A from other sources |
| a_out | output | 8 | Observed value of bus A (driven value when a_oe=1) |
| a_oe | output | 1 | Block drives bus A |
| b_in | input | 8 | Value seen on bus B from other sources |
| b_out | output | 8 | Observed value of bus B (driven value when b_oe=1) |
| b_oe | output | 1 | Block drives bus B |

## Verification
The bench captures data while both enables are off and then reveals it through the crossed stored mode. A design that gated capture with an enable or a select would show stale zeros here. It forms the live loop from a one-way live state and then changes both external inputs. A keeper that stayed transparent, or that latched the hidden external input instead of the resolved bus, would let a new value through. It also stores one bus into both registers, resets one register while keeping the other, and holds the enables active during reset. A swapped enable polarity, a register fed from the wrong bus, or a reset that failed to gate the enables would each show up as a mismatch against the step-by-step model.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int unsigned XCVR_W = 8;

    // How the block treats one bus.
    typedef enum logic [1:0] {
        DRV_OFF    = 2'd0,
        DRV_LIVE   = 2'd1,
        DRV_STORED = 2'd2
    } drv_mode_e;

    typedef struct packed {
        logic enabled;
        logic use_reg;
    } dir_ctl_t;

    function automatic drv_mode_e pick_mode(input dir_ctl_t c);
        if (!c.enabled)
            return DRV_OFF;
        else if (c.use_reg)
            return DRV_STORED;
        else
            return DRV_LIVE;
    endfunction

    function automatic logic is_live(input drv_mode_e m);
        return m == DRV_LIVE;
    endfunction

endpackage

// File: rtl/xcvr_store_reg.sv
module xcvr_store_reg #(
    parameter int unsigned W = xcvr_pkg::XCVR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= d;
    end
endmodule

// File: rtl/xcvr_dir_ctl.sv
module xcvr_dir_ctl
    import xcvr_pkg::*;
#(
    parameter bit EN_ACTIVE_LOW = 1'b0
) (
    input  logic      rst,
    input  logic      en_pin,
    input  logic      sel,
    output drv_mode_e mode
);
    logic     en_true;
    dir_ctl_t ctl;

    generate
        if (EN_ACTIVE_LOW) begin : g_low
            assign en_true = ~en_pin;
        end else begin : g_high
            assign en_true = en_pin;
        end
    endgenerate

    always_comb begin
        ctl.enabled = en_true & ~rst;
        ctl.use_reg = sel;
        mode        = pick_mode(ctl);
    end
endmodule

// File: rtl/xcvr_resolve.sv
module xcvr_resolve
    import xcvr_pkg::*;
#(
    parameter int unsigned W = XCVR_W
) (
    input  drv_mode_e    mode_a,
    input  drv_mode_e    mode_b,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic [W-1:0] q_a,
    input  logic [W-1:0] q_b,
    output logic [W-1:0] res_a,
    output logic [W-1:0] res_b
);
    logic         live_a, live_b, loop_on;
    logic [W-1:0] side_a, side_b, pre_a, pre_b;
    logic [W-1:0] keep_a, keep_b;

    always_comb begin
        live_a  = is_live(mode_a);
        live_b  = is_live(mode_b);
        loop_on = live_a & live_b;
        // Bus value when that bus is not taking live data.
        side_a  = (mode_a == DRV_STORED) ? q_b : a_in;
        side_b  = (mode_b == DRV_STORED) ? q_a : b_in;
        pre_a   = live_a ? side_b : side_a;
        pre_b   = live_b ? side_a : side_b;
    end

    // Bus keeper: transparent until both directions pass live data.
    always_latch begin
        if (!loop_on) begin
            keep_a <= pre_a;
            keep_b <= pre_b;
        end
    end

    assign res_a = loop_on ? keep_a : pre_a;
    assign res_b = loop_on ? keep_b : pre_b;
endmodule

// File: rtl/dual_reg_xcvr.sv
module dual_reg_xcvr
    import xcvr_pkg::*;
#(
    parameter int unsigned W = XCVR_W
) (
    input  logic         clk_ab,
    input  logic         clk_ba,
    input  logic         rst,
    input  logic         oe_ab,
    input  logic         oe_ba_n,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_oe
);
    drv_mode_e    mode_a, mode_b;
    logic [W-1:0] q_a, q_b;
    logic [W-1:0] res_a, res_b;

    xcvr_dir_ctl #(.EN_ACTIVE_LOW(1'b0)) u_ctl_b (
        .rst(rst), .en_pin(oe_ab), .sel(sel_ab), .mode(mode_b)
    );

    xcvr_dir_ctl #(.EN_ACTIVE_LOW(1'b1)) u_ctl_a (
        .rst(rst), .en_pin(oe_ba_n), .sel(sel_ba), .mode(mode_a)
    );

    xcvr_resolve #(.W(W)) u_res (
        .mode_a(mode_a), .mode_b(mode_b),
        .a_in(a_in), .b_in(b_in),
        .q_a(q_a), .q_b(q_b),
        .res_a(res_a), .res_b(res_b)
    );

    xcvr_store_reg #(.W(W)) u_reg_a (
        .clk(clk_ab), .rst(rst), .d(res_a), .q(q_a)
    );

    xcvr_store_reg #(.W(W)) u_reg_b (
        .clk(clk_ba), .rst(rst), .d(res_b), .q(q_b)
    );

    assign a_out = res_a;
    assign b_out = res_b;
    assign a_oe  = (mode_a != DRV_OFF);
    assign b_oe  = (mode_b != DRV_OFF);
endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
    parameter int unsigned W = 8
) (
    input logic         clk_ab,
    input logic         clk_ba,
    input logic         rst,
    input logic         oe_ab,
    input logic         oe_ba_n,
    input logic         sel_ab,
    input logic         sel_ba,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic [W-1:0] a_out,
    input logic [W-1:0] b_out,
    input logic         a_oe,
    input logic         b_oe,
    input logic [W-1:0] q_a,
    input logic [W-1:0] q_b
);
    logic [W-1:0] seen_a, seen_b;
    assign seen_a = a_oe ? a_out : a_in;
    assign seen_b = b_oe ? b_out : b_in;

    assert_cap_a_R2: assert property (@(posedge clk_ab) disable iff (rst)
        !rst |=> q_a == $past(seen_a));

    assert_cap_b_R3: assert property (@(posedge clk_ba) disable iff (rst)
        !rst |=> q_b == $past(seen_b));

    assert_b_en_R4: assert property (@(posedge clk_ab) disable iff (rst)
        b_oe |-> oe_ab);

    assert_a_en_R4: assert property (@(posedge clk_ba) disable iff (rst)
        a_oe |-> !oe_ba_n);

    assert_b_stored_R5: assert property (@(posedge clk_ab) disable iff (rst)
        (b_oe && sel_ab) |-> b_out == q_a);

    assert_a_stored_R5: assert property (@(posedge clk_ba) disable iff (rst)
        (a_oe && sel_ba) |-> a_out == q_b);

    assert_b_live_R6: assert property (@(posedge clk_ab) disable iff (rst)
        (b_oe && !sel_ab && !a_oe) |-> b_out == a_in);

    assert_a_live_R6: assert property (@(posedge clk_ba) disable iff (rst)
        (a_oe && !sel_ba && !b_oe) |-> a_out == b_in);

    assert_isolate_R11: assert property (@(posedge clk_ab) disable iff (rst)
        (!oe_ab && oe_ba_n) |-> (!a_oe && !b_oe && a_out == a_in && b_out == b_in));

    assert_rst_clear_R10: assert property (@(posedge clk_ab) disable iff (rst)
        $past(rst) |-> q_a == '0);
endmodule

bind dual_reg_xcvr xcvr_checker #(.W(W)) u_chk (
    .clk_ab(clk_ab), .clk_ba(clk_ba), .rst(rst),
    .oe_ab(oe_ab), .oe_ba_n(oe_ba_n), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_in(a_in), .b_in(b_in), .a_out(a_out), .b_out(b_out),
    .a_oe(a_oe), .b_oe(b_oe), .q_a(q_a), .q_b(q_b)
);

// File: tb/dual_reg_xcvr_test.sv
`timescale 1ns/1ps
module dual_reg_xcvr_test;
    logic       tb_clk = 1'b0;
    logic       clk_ab = 1'b0, clk_ba = 1'b0;
    logic       rst = 1'b1;
    logic       oe_ab = 1'b0, oe_ba_n = 1'b1, sel_ab = 1'b0, sel_ba = 1'b0;
    logic [7:0] a_in = 8'h00, b_in = 8'h00;
    logic [7:0] a_out, b_out;
    logic       a_oe, b_oe;

    int n_tests = 0;
    int n_fail  = 0;

    // behavioural reference state
    int m_ra = 0, m_rb = 0, m_ka = 0, m_kb = 0;
    int obs_a, obs_b;
    bit ex_aoe, ex_boe;

    always #2 tb_clk = ~tb_clk;

    dual_reg_xcvr uut (
        .clk_ab(clk_ab), .clk_ba(clk_ba), .rst(rst),
        .oe_ab(oe_ab), .oe_ba_n(oe_ba_n), .sel_ab(sel_ab), .sel_ba(sel_ba),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    initial begin
        repeat (100000) @(posedge tb_clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    function automatic bit in_loop();
        return !rst && oe_ab && !sel_ab && !oe_ba_n && !sel_ba;
    endfunction

    // Work out what each bus shows from the rules alone.
    task automatic model_bus();
        bit da, db;
        da = !rst && !oe_ba_n;
        db = !rst && oe_ab;
        ex_aoe = da;
        ex_boe = db;
        if (da && !sel_ba && db && !sel_ab) begin
            obs_a = m_ka;
            obs_b = m_kb;
        end else if (db && !sel_ab) begin
            obs_a = da ? m_rb : int'(a_in);
            obs_b = obs_a;
        end else if (da && !sel_ba) begin
            obs_b = db ? m_ra : int'(b_in);
            obs_a = obs_b;
        end else begin
            obs_a = da ? m_rb : int'(a_in);
            obs_b = db ? m_ra : int'(b_in);
        end
        if (!(da && !sel_ba && db && !sel_ab)) begin
            m_ka = obs_a;
            m_kb = obs_b;
        end
    endtask

    task automatic step(input bit r, input bit eab, input bit eban,
                        input bit sab, input bit sba,
                        input logic [7:0] ai, input logic [7:0] bi,
                        input bit pab, input bit pba, input string tag);
        @(negedge tb_clk);
        rst = r; oe_ab = eab; oe_ba_n = eban; sel_ab = sab; sel_ba = sba;
        a_in = ai; b_in = bi;
        #0.5;
        model_bus();
        @(posedge tb_clk);
        if (pab) m_ra = rst ? 0 : obs_a;
        if (pba) m_rb = rst ? 0 : obs_b;
        clk_ab = pab;
        clk_ba = pba;
        @(negedge tb_clk);
        clk_ab = 1'b0;
        clk_ba = 1'b0;
        #1;
        model_bus();
        n_tests++;
        if (a_oe !== ex_aoe || b_oe !== ex_boe ||
            a_out !== 8'(obs_a) || b_out !== 8'(obs_b)) begin
            n_fail++;
            $display("FAIL %s: a_oe=%0b b_oe=%0b a_out=%02h b_out=%02h expected a_oe=%0b b_oe=%0b a_out=%02h b_out=%02h",
                     tag, a_oe, b_oe, a_out, b_out, ex_aoe, ex_boe,
                     obs_a[7:0], obs_b[7:0]);
        end
    endtask

    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        // R10: enables held active during reset; no drive, registers cleared
        step(1, 1, 0, 1, 1, 8'h11, 8'h22, 1, 1, "R10 reset gates enables");
        step(0, 1, 0, 1, 1, 8'h5A, 8'hC3, 0, 0, "R10 registers cleared");
        // R11 isolation with capture that ignores enables (R2, R3)
        step(0, 0, 1, 0, 0, 8'h3C, 8'h96, 0, 0, "R11 isolation");
        step(0, 0, 1, 1, 0, 8'h3C, 8'h96, 1, 1, "R2 R3 capture while isolated");
        // R7: crossed stored transfer, inputs changed
        step(0, 1, 0, 1, 1, 8'hFF, 8'h00, 0, 0, "R7 crossed stored");
        // R6 / R1 live A to B
        step(0, 1, 1, 0, 0, 8'hA5, 8'h00, 0, 0, "R6 R1 live A->B a5");
        step(0, 1, 1, 0, 0, 8'h01, 8'h00, 0, 0, "R6 R1 live A->B 01");
        step(0, 1, 1, 0, 0, 8'h80, 8'h00, 0, 0, "R6 R1 live A->B 80");
        // R6 live B to A
        step(0, 0, 0, 0, 0, 8'h00, 8'h7E, 0, 0, "R6 live B->A");
        // R9 store A into both registers
        step(0, 1, 1, 0, 0, 8'h42, 8'h99, 1, 1, "R9 store A both");
        step(0, 1, 0, 1, 1, 8'h00, 8'hFF, 0, 0, "R9 A value in both regs");
        // R9 store B into both registers
        step(0, 0, 0, 0, 0, 8'h18, 8'h81, 1, 1, "R9 store B both");
        step(0, 1, 0, 1, 1, 8'hFF, 8'h00, 0, 0, "R9 B value in both regs");
        // R8 live loop entered from one-way live state
        step(0, 1, 1, 0, 0, 8'h6D, 8'h24, 0, 0, "R8 pre-loop A->B");
        step(0, 1, 0, 0, 0, 8'h6D, 8'h24, 0, 0, "R8 loop formed");
        step(0, 1, 0, 0, 0, 8'h12, 8'h34, 0, 0, "R8 loop ignores inputs");
        step(0, 1, 0, 0, 0, 8'hF0, 8'h0F, 1, 1, "R8 R2 R3 capture in loop");
        step(0, 1, 0, 1, 1, 8'h00, 8'h00, 0, 0, "R8 loop value stored");
        // R5: stored drive per direction
        step(0, 1, 1, 1, 0, 8'h77, 8'h00, 0, 0, "R5 stored A to B");
        step(0, 0, 0, 0, 1, 8'h00, 8'h55, 0, 0, "R5 stored B to A");
        // R4 enable polarity
        step(0, 0, 1, 1, 1, 8'hC0, 8'h0C, 0, 0, "R4 both disabled");
        step(0, 1, 1, 1, 1, 8'hC0, 8'h0C, 0, 0, "R4 only B driven");
        step(0, 0, 0, 1, 1, 8'hC0, 8'h0C, 0, 0, "R4 only A driven");
        // R10 reset clears only the clocked register
        step(0, 0, 1, 0, 0, 8'hE7, 8'h7E, 1, 1, "R2 R3 load before reset");
        step(1, 0, 1, 0, 0, 8'h00, 8'h00, 1, 0, "R10 reset A reg only");
        step(0, 1, 0, 1, 1, 8'h00, 8'h00, 0, 0, "R10 A cleared B kept");
        // mixed sequence
        for (int i = 0; i < 300; i++) begin
            bit r, e1, e2, s1, s2, nl, wl;
            logic [7:0] na, nb;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            r  = (lfsr[3:0] == 4'hF);
            e1 = lfsr[4]; e2 = lfsr[5]; s1 = lfsr[6]; s2 = lfsr[7];
            na = lfsr[15:8] ^ 8'h3A;
            nb = lfsr[7:0]  ^ lfsr[15:8];
            wl = in_loop();
            nl = !r && e1 && !s1 && !e2 && !s2;
            if (nl && !wl) begin
                na = a_in;
                nb = b_in;
            end
            step(r, e1, e2, s1, s2, na, nb, lfsr[9], lfsr[11], "R2 R3 R5 R6 mixed");
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule